// File: doc/BRIEF.md
# Machine Cycle Timing Generator

This block derives the internal timing of a small 8-bit controller core from one master clock. A prescaler splits the master clock into states of three master periods each, and a one-hot ring counts five states to form one machine cycle, so a cycle spans fifteen master periods. With a 6 MHz master clock the state rate is 2 MHz.

The state clock is not a separate clock net: it is a one-master-cycle enable pulse (`state_tick`) marking the first master period of every state. The core reads the current state from a one-hot vector and gets an address-latch-enable strobe that is high for the whole first state of every cycle. A copy of the state pulse can be sent to a test pin; the core turns it on with a command pulse, and only reset turns it off again.

Top module: `mcyc_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `state_onehot` = 5'b00001 (state S1 in bit 0), `ale` = 1, `state_tick` = 1 and `test_clk` = 0.
- R2: `state_tick` is high for exactly one master cycle out of every three; counting t rising edges since reset was released, it is high when t mod 3 is 0.
- R3: `state_onehot` always has exactly one bit set and changes only at the edge where `state_tick` rises, so each state lasts three master cycles.
- R4: States advance from bit 0 to bit 4 in order and wrap from bit 4 back to bit 0; the active bit after t edges since reset is bit (t/3) mod 5, a cycle of fifteen master periods.
- R5: `ale` is high exactly while bit 0 (S1) of `state_onehot` is set and low in states S2 to S5, rising at the start of every machine cycle.
- R6: `test_clk` stays 0 until `tclk_en_cmd` is sampled high at a rising edge; from that edge on, `test_clk` equals `state_tick`, whichever state phase the command arrives in.
- R7: Once enabled, the test-pin copy stays enabled; further commands have no effect, and after a reset `test_clk` stays 0 until a new command.
- R8: A reset applied in the middle of a state or cycle returns both dividers to their first count at that edge, and a command sampled while reset is high does not enable the test pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_en_cmd | input | 1 | Pulse that enables the state-clock copy on the test pin |
| state_tick | output | 1 | One-master-cycle pulse at the start of every state |
| state_onehot | output | 5 | Current state, bit 0 = S1 through bit 4 = S5 |
| ale | output | 1 | Address latch enable, high during S1 |
| test_clk | output | 1 | Gated copy of `state_tick` for the test pin |

## Verification
The hardest case is the enable command landing on the very edge where a state wraps, because the test pin must then pulse in the same cycle as `state_tick` with no one-cycle lag. The bench releases reset and then waits zero, one and two master cycles before issuing the command, so the command meets every prescaler phase, including the wrapping one. It also resets in the middle of a state with a command held high, to show that reset wins and the dividers restart from S1.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  // Default division ratios of the timing chain.
  localparam int DEF_PRE_DIV    = 3;
  localparam int DEF_NUM_STATES = 5;
endpackage

// File: rtl/mcyc_prescale.sv
// Divides the master clock into state periods of DIV master cycles.
module mcyc_prescale #(
  parameter int DIV = mcyc_pkg::DEF_PRE_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic wrap_o,   // last master cycle of the current state
  output logic tick_o    // first master cycle of the current state
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  assign wrap_o = (cnt_q == LAST);
  assign tick_o = tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= wrap_o ? '0 : cnt_q + 1'b1;
      tick_q <= wrap_o;
    end
  end
endmodule

// File: rtl/mcyc_ring.sv
// One-hot state ring plus the cycle-start strobe.
module mcyc_ring #(
  parameter int N = mcyc_pkg::DEF_NUM_STATES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [N-1:0] state_o,
  output logic         ale_o
);
  logic [N-1:0] st;
  logic         ale_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int PREV = (i == 0) ? N - 1 : i - 1;
    localparam logic INIT = (i == 0) ? 1'b1 : 1'b0;
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)        bit_q <= INIT;
      else if (adv_i) bit_q <= st[PREV];
    end
    assign st[i] = bit_q;
  end

  // ALE follows the state that is about to be entered.
  always_ff @(posedge clk) begin
    if (rst)        ale_q <= 1'b1;
    else if (adv_i) ale_q <= st[N-1];
  end

  assign state_o = st;
  assign ale_o   = ale_q;
endmodule

// File: rtl/mcyc_testpin.sv
// Sticky enable for the state-clock copy on the test pin.
module mcyc_testpin (
  input  logic clk,
  input  logic rst,
  input  logic cmd_i,
  input  logic wrap_i,
  output logic pin_o
);
  logic en_q, pin_q, en_nxt;

  assign en_nxt = en_q | cmd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      pin_q <= en_nxt & wrap_i;
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer #(
  parameter int PRE_DIV    = mcyc_pkg::DEF_PRE_DIV,
  parameter int NUM_STATES = mcyc_pkg::DEF_NUM_STATES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tclk_en_cmd,
  output logic                  state_tick,
  output logic [NUM_STATES-1:0] state_onehot,
  output logic                  ale,
  output logic                  test_clk
);
  logic wrap;

  mcyc_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .wrap_o (wrap),
    .tick_o (state_tick)
  );

  mcyc_ring #(.N(NUM_STATES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (wrap),
    .state_o (state_onehot),
    .ale_o   (ale)
  );

  mcyc_testpin u_tpin (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (tclk_en_cmd),
    .wrap_i (wrap),
    .pin_o  (test_clk)
  );
endmodule

// File: rtl/mcyc_timer_chk.sv
module mcyc_timer_chk #(
  parameter int PRE_DIV    = 3,
  parameter int NUM_STATES = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tclk_en_cmd,
  input logic                  state_tick,
  input logic [NUM_STATES-1:0] state_onehot,
  input logic                  ale,
  input logic                  test_clk
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_onehot) == 1);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !state_tick |-> $stable(state_onehot));

  a_r2_gap: assert property (@(posedge clk) disable iff (rst)
    state_tick |=> !state_tick);

  a_r4_rotate: assert property (@(posedge clk) disable iff (rst)
    (state_tick && !$past(rst)) |->
      state_onehot == {$past(state_onehot[NUM_STATES-2:0]), $past(state_onehot[NUM_STATES-1])});

  a_r5_ale_s1: assert property (@(posedge clk) disable iff (rst)
    ale == state_onehot[0]);

  a_r6_pin_gated: assert property (@(posedge clk) disable iff (rst)
    test_clk |-> state_tick);

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_onehot[0] && state_tick && !test_clk));
endmodule

bind mcyc_timer mcyc_timer_chk #(.PRE_DIV(PRE_DIV), .NUM_STATES(NUM_STATES)) u_chk (.*);

// File: tb/mcyc_timer_test.sv
module mcyc_timer_test;
  localparam int NS = 5;

  typedef struct {
    string          phase;
    logic [NS-1:0]  onehot;
    logic           ale;
    logic           tick;
    logic           tclk;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tclk_en_cmd = 1'b0;
  logic          state_tick, ale, test_clk;
  logic [NS-1:0] state_onehot;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t sb[$];

  // bench model state
  int  m_t  = 0;
  bit  m_en = 1'b0;

  always #2 clk = ~clk;

  mcyc_timer uut (
    .clk          (clk),
    .rst          (rst),
    .tclk_en_cmd  (tclk_en_cmd),
    .state_tick   (state_tick),
    .state_onehot (state_onehot),
    .ale          (ale),
    .test_clk     (test_clk)
  );

  // Driver: sets inputs for the next rising edge and queues the expected outputs.
  task automatic drive(input bit r, input bit c, input string ph);
    exp_t e;
    int   st;
    @(negedge clk);
    rst = r;
    tclk_en_cmd = c;
    if (r) begin
      m_t  = 0;
      m_en = 1'b0;
    end else begin
      m_t  = (m_t + 1) % 15;
      m_en = m_en | c;
    end
    st       = (m_t / 3) % NS;
    e.phase  = ph;
    e.onehot = NS'(1) << st;
    e.ale    = (st == 0);
    e.tick   = (m_t % 3 == 0);
    e.tclk   = m_en && (m_t % 3 == 0);
    sb.push_back(e);
  endtask

  task automatic chk(input string ph, input string req, input string fld,
                     input logic [NS-1:0] got, input logic [NS-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s %s: actual %b expected %b", ph, req, fld, got, exp);
    end
  endtask

  // Monitor: one expected item per rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.phase, "R3 R4", "state_onehot", state_onehot, e.onehot);
      chk(e.phase, "R5", "ale", NS'(ale), NS'(e.ale));
      chk(e.phase, "R2", "state_tick", NS'(state_tick), NS'(e.tick));
      chk(e.phase, "R6 R7", "test_clk", NS'(test_clk), NS'(e.tclk));
    end
  end

  initial begin
    fork
      begin
        // R1: reset state
        repeat (3) drive(1, 0, "R1 reset");
        // R2 R3 R4 R5: free run, two full cycles and more, pin disabled
        repeat (40) drive(0, 0, "R4 free run");
        // R6: command at each prescaler phase after reset
        for (int ph = 0; ph < 3; ph++) begin
          drive(1, 0, "R8 reset");
          for (int k = 0; k < ph; k++) drive(0, 0, "R6 pre-command");
          drive(0, 1, "R6 command");
          repeat (20) drive(0, 0, "R6 enabled");
          // R7: repeat command has no effect
          drive(0, 1, "R7 second command");
          repeat (7) drive(0, 0, "R7 still enabled");
        end
        // R8: mid-state reset with command held
        repeat (4) drive(0, 0, "R8 before reset");
        drive(1, 1, "R8 reset with command");
        drive(1, 1, "R8 reset with command");
        // R7: pin stays off after reset until a new command
        repeat (25) drive(0, 0, "R7 off after reset");
        drive(0, 1, "R7 re-enable");
        repeat (16) drive(0, 0, "R7 re-enabled");
        @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule